// File: doc/BRIEF.md
# Table-Driven Swap Sign Selector

This block serves a serial two-capacitor DAC that swaps which capacitor is charged in each bit cycle. For every input word it picks the swap vector, one bit per bit cycle, so that the first-order mismatch error term lands close to a target value. The target comes from a noise-shaping loop filter. A swap bit of 1 means the first capacitor is charged in that cycle (weight +1). A swap bit of 0 means the second capacitor is charged (weight -1).

The four swap bits that carry the most weight come from a search table. The table is indexed by the top four input bits and by the top four bits of the target. The remaining swap bits follow the polarity of the target through a bitwise XNOR with the lower input bits. The table is filled at elaboration from a numerical search over all sixteen codes, so it does not depend on any capacitor value. The result is registered and presented with a valid strobe one cycle after the inputs are accepted.

Top module: `sgn_sel`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `t_word` become 0 at that edge.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: `t_word` keeps its value across every cycle in which `in_valid` is low.
- R4: Let a = `x_word[N-1:N-4]`, with bit i of a at position i = 0..3. Let v = `nu[NU_W-1:NU_W-4]`, read as a signed number. Define B_i = (a[i] ? 2^(i+1) : 0) - (1 + sum over p<i of a[p]*2^(p+1)). For each code c, S(c) = sum over i of (c[i] ? +B_i : -B_i). `t_word[N-1:N-4]` is the code c in 0..15 that minimises |S(c) - 4*v|.
- R5: When several codes reach the same minimal distance in R4, the numerically lowest code is chosen.
- R6: For every j < N-4, `t_word[j]` = XNOR(`x_word[j]`, s), where s = 1 when `nu` is zero or positive (its MSB is 0) and s = 0 when `nu` is negative.
- R7: `x_word[N-5:0]` has no effect on `t_word[N-1:N-4]`.
- R8: `nu[NU_W-5:0]` has no effect on any bit of `t_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `x_word` and `nu` this cycle |
| x_word | input | N | Input word, MSB first in weight |
| nu | input | NU_W | Signed target for the mismatch error |
| out_valid | output | 1 | `t_word` holds a new result |
| t_word | output | N | Swap vector, 1 = first capacitor charged |

## Verification
The bench goes after the table extremes:
- An all-zero and an all-one top nibble with the most negative and most positive targets, where a reversed sign convention returns the bitwise complement of the right code.
- A zero target with an all-zero nibble, which gives a six-way tie. A tie-break that kept the last best code would answer 12 instead of 3.
- A zero `nu`, which must count as positive. A sign test that treated zero as negative would invert every lower bit.
- Pairs of words that differ only in the lower input bits or only in the lower target bits. A table indexed with the wrong bits would change its top nibble between the two.

// File: rtl/sgn_sel_pkg.sv
// Package: shared arithmetic for the swap sign selector table.
// Assumes a four-bit table slice, with bit 0 as the least weighted of the
// four table positions. All values are scaled by 16 so they stay integers.
package sgn_sel_pkg;

    localparam int TBL_BITS = 4;
    localparam int TBL_ADDR = 2 * TBL_BITS;
    localparam int TBL_SIZE = 1 << TBL_ADDR;

    // Scaled mismatch coefficient of table position i for nibble a.
    // The word below the nibble is taken as a single 1 followed by zeros.
    function automatic int coef(input logic [TBL_BITS-1:0] a, input int i);
        int below;
        below = 1;
        for (int p = 0; p < i; p++) begin
            if (a[p]) below = below + (1 << (p + 1));
        end
        return (a[i] ? (1 << (i + 1)) : 0) - below;
    endfunction

    // Scaled error reached by swap code c for nibble a.
    function automatic int err_of(input logic [TBL_BITS-1:0] a,
                                  input logic [TBL_BITS-1:0] c);
        int s;
        s = 0;
        for (int i = 0; i < TBL_BITS; i++) begin
            if (c[i]) s = s + coef(a, i);
            else      s = s - coef(a, i);
        end
        return s;
    endfunction

    // Lowest code whose error is closest to the truncated target v/4.
    function automatic logic [TBL_BITS-1:0] pick_code(
            input logic [TBL_BITS-1:0] a,
            input logic [TBL_BITS-1:0] v);
        int target;
        int best_d;
        int d;
        logic [TBL_BITS-1:0] best_c;
        target = 4 * int'($signed(v));
        best_d = 1 << 20;
        best_c = '0;
        for (int c = 0; c < (1 << TBL_BITS); c++) begin
            d = err_of(a, TBL_BITS'(c)) - target;
            if (d < 0) d = -d;
            if (d < best_d) begin
                best_d = d;
                best_c = TBL_BITS'(c);
            end
        end
        return best_c;
    endfunction

    // One bit plane of the table, addressed by {nibble, target}.
    function automatic logic [TBL_SIZE-1:0] plane_of(input int b);
        logic [TBL_SIZE-1:0] pl;
        logic [TBL_BITS-1:0] code;
        pl = '0;
        for (int n = 0; n < TBL_SIZE; n++) begin
            code  = pick_code(TBL_BITS'(n >> TBL_BITS), TBL_BITS'(n));
            pl[n] = code[b];
        end
        return pl;
    endfunction

endpackage

// File: rtl/sgn_sel_plane.sv
// Module: one hardwired bit plane of the swap code table.
// Assumes the address is {top input nibble, truncated target nibble}.
// The contents are constant and built at elaboration time.
module sgn_sel_plane
    import sgn_sel_pkg::*;
#(
    parameter int BIT_IDX = 0
) (
    input  logic [TBL_ADDR-1:0] addr,
    output logic                bit_o
);

    localparam logic [TBL_SIZE-1:0] PLANE = plane_of(BIT_IDX);

    // Look up this plane's bit.
    always_comb begin
        bit_o = PLANE[addr];
    end

endmodule

// File: rtl/sgn_sel_target.sv
// Module: splits the signed target into its table nibble and its sign.
// Assumes two's complement; zero counts as positive (pos = 1).
module sgn_sel_target
    import sgn_sel_pkg::*;
#(
    parameter int NU_W = 8
) (
    input  logic [NU_W-1:0]     nu,
    output logic [TBL_BITS-1:0] nu_trunc,
    output logic                pos
);

    localparam int MSB = NU_W - 1;

    // Keep the top bits and derive the polarity flag.
    always_comb begin
        nu_trunc = nu[MSB -: TBL_BITS];
        pos      = ~nu[MSB];
    end

endmodule

// File: rtl/sgn_sel_lsb.sv
// Module: polarity rule for the swap bits below the table slice.
// Assumes pos = 1 asks for a positive partial error sum.
module sgn_sel_lsb #(
    parameter int W = 12
) (
    input  logic [W-1:0] x_low,
    input  logic         pos,
    output logic [W-1:0] t_low
);

    // Bitwise XNOR of each lower input bit with the polarity flag.
    always_comb begin
        t_low = ~(x_low ^ {W{pos}});
    end

endmodule

// File: rtl/sgn_sel.sv
// Module: table-driven swap sign selector (top).
// Chooses the swap vector for one input word per accepted cycle and
// registers it, so the result is valid one cycle after acceptance.
// Assumes N > TBL_BITS and NU_W >= TBL_BITS.
module sgn_sel
    import sgn_sel_pkg::*;
#(
    parameter int N    = 16,
    parameter int NU_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [N-1:0]    x_word,
    input  logic [NU_W-1:0] nu,
    output logic            out_valid,
    output logic [N-1:0]    t_word
);

    localparam int LOW_W = N - TBL_BITS;

    logic [TBL_BITS-1:0] nu_trunc;
    logic                pos;
    logic [TBL_ADDR-1:0] tbl_addr;
    logic [TBL_BITS-1:0] top_code;
    logic [LOW_W-1:0]    low_code;

    sgn_sel_target #(.NU_W(NU_W)) u_target (
        .nu       (nu),
        .nu_trunc (nu_trunc),
        .pos      (pos)
    );

    // Form the table address from the top input nibble and target nibble.
    always_comb begin
        tbl_addr = {x_word[N-1 -: TBL_BITS], nu_trunc};
    end

    for (genvar b = 0; b < TBL_BITS; b++) begin : g_plane
        sgn_sel_plane #(.BIT_IDX(b)) u_plane (
            .addr  (tbl_addr),
            .bit_o (top_code[b])
        );
    end

    sgn_sel_lsb #(.W(LOW_W)) u_lsb (
        .x_low (x_word[LOW_W-1:0]),
        .pos   (pos),
        .t_low (low_code)
    );

    // Register the swap vector and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            t_word    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) t_word <= {top_code, low_code};
        end
    end

endmodule

// File: rtl/sgn_sel_chk.sv
// Checker: temporal properties of the swap sign selector ports.
module sgn_sel_chk #(
    parameter int N    = 16,
    parameter int NU_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [N-1:0]    x_word,
    input logic [NU_W-1:0] nu,
    input logic            out_valid,
    input logic [N-1:0]    t_word
);

    localparam int LOW_W = N - 4;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && t_word == '0));

    // R2
    strobe_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    strobe_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(t_word));

    // R6
    low_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (t_word[LOW_W-1:0] ==
            ($past(nu[NU_W-1]) ? ~$past(x_word[LOW_W-1:0])
                               :  $past(x_word[LOW_W-1:0]))));

endmodule

bind sgn_sel sgn_sel_chk #(.N(N), .NU_W(NU_W)) u_sgn_sel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_word    (x_word),
    .nu        (nu),
    .out_valid (out_valid),
    .t_word    (t_word)
);

// File: tb/sgn_sel_bench.sv
// Scoreboard bench for the swap sign selector.
module sgn_sel_bench;

    localparam int N    = 16;
    localparam int NU_W = 8;

    typedef struct {
        logic [N-1:0] t;
        string        tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N-1:0]    x_word = '0;
    logic [NU_W-1:0] nu = '0;
    logic            out_valid;
    logic [N-1:0]    t_word;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];
    logic [N-1:0] last_t = '0;
    logic run_mon = 1'b0;

    always #2 clk = ~clk;

    sgn_sel #(.N(N), .NU_W(NU_W)) u_sgn_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_word(x_word),
        .nu(nu), .out_valid(out_valid), .t_word(t_word)
    );

    // Reference top nibble: distance search in real arithmetic.
    function automatic logic [3:0] ref_top(input logic [N-1:0] x,
                                           input logic [NU_W-1:0] v);
        real bits [0:4];
        real b [0:3];
        real target, s, d, best_d;
        logic [3:0] best;
        bits[0] = 1.0;
        for (int i = 0; i < 4; i++) bits[i+1] = x[N-4+i] ? 1.0 : 0.0;
        for (int i = 0; i < 4; i++) begin
            s = 0.0;
            for (int j = 0; j <= i; j++) s = s + bits[j] * (2.0 ** (j - i - 1));
            b[i] = (bits[i+1] - s) * (2.0 ** (i - 3));
        end
        target = real'($signed(v[NU_W-1 -: 4])) / 4.0;
        best_d = 1.0e9;
        best = 4'd0;
        for (int c = 0; c < 16; c++) begin
            s = 0.0;
            for (int i = 0; i < 4; i++) s = s + (c[i] ? b[i] : -b[i]);
            d = (s > target) ? s - target : target - s;
            if (d < best_d) begin
                best_d = d;
                best = 4'(c);
            end
        end
        return best;
    endfunction

    function automatic logic [N-1:0] ref_t(input logic [N-1:0] x,
                                           input logic [NU_W-1:0] v);
        logic [N-5:0] lo;
        for (int j = 0; j < N - 4; j++) lo[j] = (v[NU_W-1] == 1'b0) ? x[j] : ~x[j];
        return {ref_top(x, v), lo};
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one word for one cycle and queue its expected result.
    task automatic drive(input logic [N-1:0] x, input logic [NU_W-1:0] v,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        x_word   = x;
        nu       = v;
        e.t   = ref_t(x, v);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            x_word   = ~x_word;
            nu       = ~nu;
        end
    endtask

    // Monitor: pop and compare results; check hold and strobe otherwise.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (run_mon) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check("R2 unexpected strobe", 16'h0001, 16'h0000);
                    end else begin
                        e = sb.pop_front();
                        check(e.tag, t_word, e.t);
                        last_t = e.t;
                    end
                end else begin
                    check("R3 hold while idle", t_word, last_t);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] r1, r2;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 reset t_word", t_word, '0);
        @(negedge clk);
        rst_n = 1'b1;
        run_mon = 1'b1;

        // R4 extremes and R5 tie: nibble 0000, zero target -> code 3.
        drive(16'h0000, 8'h00, "R5 tie lowest code, R6 zero positive");
        drive(16'h0000, 8'h80, "R4 nibble 0 most negative target");
        drive(16'h0000, 8'h70, "R4 nibble 0 most positive target");
        drive(16'hF000, 8'h70, "R4 nibble F most positive target");
        drive(16'h8000, 8'h30, "R4 nibble 8 exact match");
        drive(16'h7ABC, 8'hC5, "R4 R6 negative target");
        idle(3);
        drive(16'h1234, 8'h11, "R3 after gap");
        idle(2);

        // Direct value checks of known table entries.
        check("R5 tie code for nibble 0 target 0", 16'(ref_top(16'h0, 8'h00)), 16'd3);
        check("R4 nibble 0 most negative code", 16'(ref_top(16'h0, 8'h80)), 16'd15);
        check("R4 nibble F most positive code", 16'(ref_top(16'hF000, 8'h70)), 16'd15);

        // R7: lower input bits do not move the top nibble.
        drive(16'hA000, 8'h2A, "R7 base");
        drive(16'hAFFF, 8'h2A, "R7 low bits flipped");
        // R8: lower target bits have no effect.
        drive(16'h5C3A, 8'hE0, "R8 base");
        drive(16'h5C3A, 8'hEF, "R8 low target bits set");
        idle(2);
        r1 = ref_t(16'h5C3A, 8'hE0);
        r2 = ref_t(16'h5C3A, 8'hEF);
        check("R8 reference invariance", r1, r2);

        // Pseudo-random back-to-back traffic with occasional gaps.
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr, lfsr[11:4] ^ 8'(i), "R4 R6 sweep");
            if (lfsr[2:0] == 3'd0) idle(1);
        end
        // Exhaustive nibble and target sweep.
        for (int a = 0; a < 16; a++) begin
            for (int v = 0; v < 16; v++) begin
                drive({4'(a), 12'h5A5}, {4'(v), 4'h9}, "R4 R5 table sweep");
            end
        end
        idle(4);
        check("R2 scoreboard drained", 16'(sb.size()), 16'd0);

        // R1: reset clears a held result.
        @(negedge clk);
        run_mon = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset clears t_word", t_word, '0);
        check("R1 reset clears out_valid", {15'd0, out_valid}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule